// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block writes a single byte into an on-chip EPROM through a parallel programming port. A controller issues a one-cycle start request together with a target kind, an address and a data byte. The sequencer then runs the whole programming recipe by itself. It presents the address, then drives the data, then asserts the target select and the programming enable, then raises the high-voltage enable. After that it issues a train of active-low programming pulses, holds everything for a settle interval, and drops the high voltage. For code-array bytes it then performs a verify read.

All intervals are counted in clock (oscillator) cycles. They are derived from microsecond parameters multiplied by the cycles-per-microsecond parameter, or from plain cycle-count parameters where the rule is stated in oscillator periods. The block reports busy for the whole sequence and a one-cycle done pulse at the end. A verify mismatch flag stays valid until the next accepted start.

Top module: `eprom_prog_seq`

## Requirements
- R1: After an accepted start the outputs come up in strict order, each in a later cycle than the one before: the target address on `pgm_addr` (first cycle after the start edge), then `pgm_data_oe` with the byte on `pgm_wdata`, then `pgm_sel` and `pgm_en`, then `vpp_en`, then the first falling edge of `prog_n`. The data is driven at least ADDR_SU_CYC (48) cycles before that first fall.
- R2: The target code on `tgt` selects the pulse count. Code 00 is the code array and gives CODE_PULSES (5) pulses. Code 01 is the encryption table and code 10 is the lock bits; both give CFG_PULSES (25) pulses. `pgm_sel` is one-hot, with bit 0 for code, bit 1 for encryption and bit 2 for lock.
- R3: Every `prog_n` low pulse lasts exactly PULSE_US*CLK_PER_US cycles.
- R4: `vpp_en` rises exactly VPP_SU_US*CLK_PER_US cycles before the first fall of `prog_n`, and is high in every cycle in which `prog_n` is low.
- R5: Between consecutive pulses `prog_n` stays high for exactly GAP_US*CLK_PER_US cycles.
- R6: After the last rise of `prog_n`, `vpp_en`, the address and the data stay driven for the larger of VPP_HD_US*CLK_PER_US and HOLD_CYC (48) cycles.
- R7: For code-array bytes the read strobe `vfy_rd_n` goes low only after `vpp_en` has fallen, and stays low for VFY_CYC (48) cycles. `rd_data` is sampled in the last of those cycles. Other targets perform no verify read.
- R8: `vfy_err` is set at the end of a code-array sequence exactly when the sampled byte differs from the written byte. It is cleared by the next accepted start and stays 0 for encryption and lock targets.
- R9: `busy` is high from the first cycle after an accepted start through the done cycle. `done` is high for exactly one cycle, after which `busy` is low.
- R10: A start while `busy` is high is ignored: address, pulse count and result are unchanged. A start carrying the reserved target code 11 is ignored and leaves the block idle.
- R11: After reset `prog_n` and `vfy_rd_n` are high, and `vpp_en`, `pgm_en`, `pgm_data_oe`, `pgm_sel`, `busy`, `done` and `vfy_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to program a byte |
| tgt | input | 2 | Target: 00 code, 01 encryption, 10 lock, 11 reserved |
| addr | input | AW | Byte address to program |
| wdata | input | DW | Byte value to program |
| rd_data | input | DW | Data bus as read back during verify |
| pgm_addr | output | AW | Address presented to the array |
| pgm_wdata | output | DW | Data presented to the array |
| pgm_data_oe | output | 1 | Data bus drive enable |
| pgm_sel | output | 3 | One-hot target select |
| pgm_en | output | 1 | Programming enable |
| vpp_en | output | 1 | High-voltage supply enable |
| prog_n | output | 1 | Active-low programming pulse |
| vfy_rd_n | output | 1 | Active-low verify read strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| vfy_err | output | 1 | Verify mismatch flag |

## Verification
The bench sweeps all three real target codes with several byte values (00, FF, alternating and sparse patterns). This separates the 5-pulse and 25-pulse trains and shows that the select encoding follows the target. For code-array bytes, each value is run once with a matching read-back and once with a corrupted one, which separates a correct compare from a stuck or inverted flag. The same runs also show that the flag clears on the next start. Runs that inject a second start mid-sequence, and a start carrying the reserved code, show apart a block that re-latches or restarts from one that ignores the request. Every pulse width, gap, supply setup and hold interval is measured against values computed from the parameters.

// File: rtl/eprog_pkg.sv
package eprog_pkg;

    typedef enum logic [1:0] {
        TGT_CODE = 2'b00,
        TGT_ENCR = 2'b01,
        TGT_LOCK = 2'b10,
        TGT_RSVD = 2'b11
    } tgt_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_CTRL,
        ST_VPP_SU,
        ST_PULSE,
        ST_GAP,
        ST_HOLD,
        ST_VOFF,
        ST_VFY,
        ST_DONE
    } st_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprog_timer.sv
module eprog_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprog_pulse_cnt.sv
module eprog_pulse_cnt #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == W'(1));

    AST_PULSE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/eprog_verify.sv
module eprog_verify #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sample,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] expected,
    output logic          mismatch
);

    logic err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (clr) begin
            err_d = 1'b0;
        end else if (sample) begin
            err_d = (rd_data != expected);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign mismatch = err_q;

    AST_ERR_RISES_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mismatch) |-> $past(sample)); // R8

    AST_ERR_CLEARED_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !mismatch); // R8

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprog_pkg::*;
#(
    parameter int unsigned AW          = 15,
    parameter int unsigned DW          = 8,
    parameter int unsigned CLK_PER_US  = 12,
    parameter int unsigned PULSE_US    = 100,
    parameter int unsigned GAP_US      = 10,
    parameter int unsigned VPP_SU_US   = 10,
    parameter int unsigned VPP_HD_US   = 10,
    parameter int unsigned ADDR_SU_CYC = 48,
    parameter int unsigned HOLD_CYC    = 48,
    parameter int unsigned VFY_CYC     = 48,
    parameter int unsigned CODE_PULSES = 5,
    parameter int unsigned CFG_PULSES  = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    tgt,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] pgm_addr,
    output logic [DW-1:0] pgm_wdata,
    output logic          pgm_data_oe,
    output logic [2:0]    pgm_sel,
    output logic          pgm_en,
    output logic          vpp_en,
    output logic          prog_n,
    output logic          vfy_rd_n,
    output logic          busy,
    output logic          done,
    output logic          vfy_err
);

    localparam int unsigned C_SU   = ADDR_SU_CYC;
    localparam int unsigned C_VSU  = VPP_SU_US * CLK_PER_US;
    localparam int unsigned C_PW   = PULSE_US * CLK_PER_US;
    localparam int unsigned C_GAP  = GAP_US * CLK_PER_US;
    localparam int unsigned C_HOLD = max2(VPP_HD_US * CLK_PER_US, HOLD_CYC);
    localparam int unsigned C_VFY  = VFY_CYC;
    localparam int unsigned C_MAX  = max2(max2(C_SU, C_VSU),
                                          max2(max2(C_PW, C_GAP), max2(C_HOLD, C_VFY)));
    localparam int unsigned TW     = $clog2(C_MAX + 1);
    localparam int unsigned PW     = $clog2(max2(CODE_PULSES, CFG_PULSES) + 1);

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        tgt_e          tgt;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          pc_load;
    logic [PW-1:0] pc_val;
    logic          pc_dec;
    logic          pc_last;
    logic          vf_clr;
    logic          vf_sample;
    tgt_e          req_tgt;

    assign req_tgt = tgt_e'(tgt);

    eprog_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    eprog_pulse_cnt #(.W(PW)) u_pulses (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pc_load),
        .load_val (pc_val),
        .dec      (pc_dec),
        .last     (pc_last)
    );

    eprog_verify #(.DW(DW)) u_verify (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (vf_clr),
        .sample   (vf_sample),
        .rd_data  (rd_data),
        .expected (ctl_q.data),
        .mismatch (vfy_err)
    );

    always_comb begin
        ctl_d     = ctl_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        pc_load   = 1'b0;
        pc_val    = '0;
        pc_dec    = 1'b0;
        vf_clr    = 1'b0;
        vf_sample = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start && (req_tgt != TGT_RSVD)) begin
                    ctl_d.st   = ST_ADDR;
                    ctl_d.addr = addr;
                    ctl_d.data = wdata;
                    ctl_d.tgt  = req_tgt;
                    pc_load    = 1'b1;
                    pc_val     = (req_tgt == TGT_CODE) ? PW'(CODE_PULSES) : PW'(CFG_PULSES);
                    vf_clr     = 1'b1;
                end
            end
            ST_ADDR: begin
                ctl_d.st = ST_DATA;
            end
            ST_DATA: begin
                ctl_d.st = ST_CTRL;
                tmr_load = 1'b1;
                tmr_val  = TW'(C_SU - 1);
            end
            ST_CTRL: begin
                if (tmr_exp) begin
                    ctl_d.st = ST_VPP_SU;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(C_VSU - 1);
                end
            end
            ST_VPP_SU: begin
                if (tmr_exp) begin
                    ctl_d.st = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(C_PW - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    pc_dec   = 1'b1;
                    tmr_load = 1'b1;
                    if (pc_last) begin
                        ctl_d.st = ST_HOLD;
                        tmr_val  = TW'(C_HOLD - 1);
                    end else begin
                        ctl_d.st = ST_GAP;
                        tmr_val  = TW'(C_GAP - 1);
                    end
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    ctl_d.st = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(C_PW - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    ctl_d.st = ST_VOFF;
                end
            end
            ST_VOFF: begin
                if (ctl_q.tgt == TGT_CODE) begin
                    ctl_d.st = ST_VFY;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(C_VFY - 1);
                end else begin
                    ctl_d.st = ST_DONE;
                end
            end
            ST_VFY: begin
                if (tmr_exp) begin
                    vf_sample = 1'b1;
                    ctl_d.st  = ST_DONE;
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, data: '0, tgt: TGT_CODE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    logic prog_window;
    logic hv_window;

    assign prog_window = (ctl_q.st == ST_CTRL)  || (ctl_q.st == ST_VPP_SU) ||
                         (ctl_q.st == ST_PULSE) || (ctl_q.st == ST_GAP)    ||
                         (ctl_q.st == ST_HOLD);
    assign hv_window   = (ctl_q.st == ST_VPP_SU) || (ctl_q.st == ST_PULSE) ||
                         (ctl_q.st == ST_GAP)    || (ctl_q.st == ST_HOLD);

    assign pgm_addr    = ctl_q.addr;
    assign pgm_wdata   = ctl_q.data;
    assign pgm_data_oe = prog_window || (ctl_q.st == ST_DATA);
    assign pgm_en      = prog_window;
    assign vpp_en      = hv_window;
    assign prog_n      = (ctl_q.st != ST_PULSE);
    assign vfy_rd_n    = (ctl_q.st != ST_VFY);
    assign busy        = (ctl_q.st != ST_IDLE);
    assign done        = (ctl_q.st == ST_DONE);

    always_comb begin
        pgm_sel = 3'b000;
        if (prog_window) begin
            case (ctl_q.tgt)
                TGT_CODE: pgm_sel = 3'b001;
                TGT_ENCR: pgm_sel = 3'b010;
                TGT_LOCK: pgm_sel = 3'b100;
                default:  pgm_sel = 3'b000;
            endcase
        end
    end

    AST_PROG_UNDER_VPP: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> vpp_en); // R4

    AST_VPP_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n) |-> $past(vpp_en)); // R4

    AST_VFY_AFTER_VPP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !vfy_rd_n |-> (!vpp_en && $past(!vpp_en))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> $stable(pgm_addr)); // R10

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |-> $onehot(pgm_sel)); // R2

    AST_DATA_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (pgm_data_oe && pgm_en)); // R6

endmodule

// File: tb/sim_eprom_prog_seq.sv
module sim_eprom_prog_seq;

    localparam int CPU   = 2;
    localparam int E_PW  = 100 * CPU;
    localparam int E_GAP = 10 * CPU;
    localparam int E_VSU = 10 * CPU;
    localparam int E_HLD = (10 * CPU > 48) ? 10 * CPU : 48;
    localparam int E_VFY = 48;
    localparam int E_SU  = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  tgt = 2'b00;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rd_data = '0;
    logic [14:0] pgm_addr;
    logic [7:0]  pgm_wdata;
    logic        pgm_data_oe;
    logic [2:0]  pgm_sel;
    logic        pgm_en, vpp_en, prog_n, vfy_rd_n, busy, done, vfy_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eprom_prog_seq #(.CLK_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt(tgt), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .pgm_addr(pgm_addr), .pgm_wdata(pgm_wdata),
        .pgm_data_oe(pgm_data_oe), .pgm_sel(pgm_sel), .pgm_en(pgm_en), .vpp_en(vpp_en),
        .prog_n(prog_n), .vfy_rd_n(vfy_rd_n), .busy(busy), .done(done), .vfy_err(vfy_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_one(input logic [1:0] t, input logic [14:0] a,
                           input logic [7:0] d, input logic [7:0] rd, input bit poke);
        int n = 0;
        int t_data = 0, t_sel = 0, t_vpp = 0, t_vpp_off = 0, t_fall = 0, t_rise = 0, t_rd = 0;
        int pulses = 0, lowlen = 0, gap = 0, bad_pw = 0, bad_gap = 0;
        int vpp_viol = 0, rdlen = 0, bad_addr = 0, bad_data = 0, busy_low = 0;
        logic [2:0] sel_seen = '0;
        bit finished = 0;
        bit prev_vpp = 0, prev_prog = 1;
        bit err_at_done = 0;
        int exp_pulses = (t == 2'b00) ? 5 : 25;
        logic [2:0] exp_sel = (t == 2'b00) ? 3'b001 : ((t == 2'b01) ? 3'b010 : 3'b100);
        bit exp_err = (t == 2'b00) && (rd != d);

        start = 1'b1; tgt = t; addr = a; wdata = d; rd_data = rd;
        while (!finished && n < 20000) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start = 1'b0;
                chk(pgm_addr == a, "R1", "address in first cycle", int'(pgm_addr), int'(a));
                chk(!pgm_data_oe && pgm_sel == 0, "R1", "data/select idle in first cycle",
                    int'({pgm_data_oe, pgm_sel}), 0);
            end
            if (poke && n == 100) begin
                start = 1'b1; addr = ~a; tgt = 2'b01;
            end
            if (poke && n == 101) start = 1'b0;
            if (pgm_data_oe && t_data == 0) t_data = n;
            if (pgm_data_oe && pgm_wdata != d) bad_data++;
            if (pgm_sel != 0 && t_sel == 0) begin t_sel = n; sel_seen = pgm_sel; end
            if (vpp_en && !prev_vpp) t_vpp = n;
            if (!vpp_en && prev_vpp) t_vpp_off = n;
            if (!prog_n && prev_prog) begin
                pulses++;
                if (pulses == 1) t_fall = n;
                else if (gap != E_GAP) bad_gap++;
                lowlen = 0;
            end
            if (!prog_n) lowlen++;
            if (prog_n && !prev_prog) begin
                if (lowlen != E_PW) bad_pw++;
                t_rise = n; gap = 0;
            end
            if (prog_n) gap++;
            if (!prog_n && !vpp_en) vpp_viol++;
            if (!vfy_rd_n) begin
                rdlen++;
                if (t_rd == 0) t_rd = n;
                if (vpp_en) vpp_viol++;
            end
            if (pgm_addr != a) bad_addr++;
            if (!busy) busy_low++;
            if (done) begin finished = 1; err_at_done = vfy_err; end
            prev_vpp = vpp_en; prev_prog = prog_n;
        end
        chk(finished, "R9", "sequence completes", n, 0);
        chk(t_data > 1 && t_sel > t_data && t_vpp > t_sel && t_fall > t_vpp, "R1",
            "order data<sel<vpp<fall", t_fall, t_vpp + 1);
        chk(t_fall - t_data >= E_SU, "R1", "data setup before first fall", t_fall - t_data, E_SU);
        chk(sel_seen == exp_sel, "R2", "target select", int'(sel_seen), int'(exp_sel));
        chk(pulses == exp_pulses, "R2", "pulse count", pulses, exp_pulses);
        chk(bad_pw == 0, "R3", "pulse width mismatches", bad_pw, 0);
        chk(t_fall - t_vpp == E_VSU, "R4", "vpp setup", t_fall - t_vpp, E_VSU);
        chk(vpp_viol == 0, "R4", "prog low or read with wrong vpp", vpp_viol, 0);
        chk(bad_gap == 0, "R5", "gap width mismatches", bad_gap, 0);
        chk(t_vpp_off - t_rise == E_HLD, "R6", "vpp hold after last rise", t_vpp_off - t_rise, E_HLD);
        chk(bad_data == 0 && bad_addr == 0, "R6", "addr/data held", bad_addr + bad_data, 0);
        chk(rdlen == ((t == 2'b00) ? E_VFY : 0), "R7", "verify read length", rdlen,
            (t == 2'b00) ? E_VFY : 0);
        if (t == 2'b00) chk(t_rd > t_vpp_off, "R7", "read after vpp off", t_rd, t_vpp_off + 1);
        chk(err_at_done == exp_err, "R8", "verify flag", int'(err_at_done), int'(exp_err));
        chk(busy_low == 0, "R9", "busy through sequence", busy_low, 0);
        if (poke) chk(pulses == exp_pulses && bad_addr == 0, "R10", "start while busy ignored",
                      pulses, exp_pulses);
        @(negedge clk);
        chk(!done && !busy, "R9", "done one cycle then idle", int'({done, busy}), 0);
        chk(vfy_err == exp_err, "R8", "flag persists after done", int'(vfy_err), int'(exp_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'h81;
        repeat (3) @(negedge clk);
        chk(prog_n && vfy_rd_n && !vpp_en && !pgm_en && !pgm_data_oe && pgm_sel == 0 &&
            !busy && !done && !vfy_err, "R11", "reset state", int'({vpp_en, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prog_n && !busy && !vpp_en, "R11", "idle after reset release", int'(busy), 0);
        for (int i = 0; i < 4; i++) begin
            run_one(2'b00, 15'(16'h1234 + i * 16'h0F0F), pats[i], pats[i], 1'b0);
            run_one(2'b00, 15'(16'h0042 + i), pats[i], pats[i] ^ 8'h10, (i == 1));
        end
        for (int i = 0; i < 2; i++) begin
            run_one(2'b01, 15'(i * 7 + 3), pats[i + 2], 8'h00, (i == 0));
            run_one(2'b10, 15'(i + 1), pats[i], 8'hFF, 1'b0);
        end
        begin
            int busy_seen = 0;
            start = 1'b1; tgt = 2'b11; addr = 15'h7FFF;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 6; k++) begin
                if (busy || !prog_n || vpp_en) busy_seen++;
                @(negedge clk);
            end
            chk(busy_seen == 0, "R10", "reserved target ignored", busy_seen, 0);
        end
        run_one(2'b00, 15'h0ABC, 8'h3C, 8'h3C, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule